// File: doc/BRIEF.md
# Twelve-Source Vectored Interrupt Arbiter

This block decides, once per machine cycle, whether an 8-bit core must break into a hardware call and, if it must, which of twelve interrupt sources is served. It combines each source flag with its own enable bit and a global enable, and splits the surviving requests into two priority levels using a per-source level bit. Inside a level, the lower source index wins. A level is eligible only while no routine at that level or above is in service, so a high-level request can pre-empt a low-level routine.

The core supplies a machine-cycle strobe and three status lines. One marks the final machine cycle of the current instruction. One flags an instruction that writes an enable or priority register. One flags a return-from-interrupt. A call is taken only on a strobed final cycle that is neither of those two instruction kinds. The block then emits a one-cycle call request with the 16-bit vector address, and sets the in-service bit for the winning level. For the sources that hardware may clear, it also pulses a clear line back to that source. Requests are not held from one poll to the next: a flag that has dropped by the time a call is allowed is simply lost.

Top module: `irq_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `vec_req`, `hw_clear` and `in_service` are all zero.
- R2: Source index i of `src_flag` has natural rank i, with index 0 highest. Among pending requests of the same level, the lowest index is served.
- R3: The vector address is 0003h + 8*i for indices 0 to 4, and 0003h + 8*(i+2) for indices 5 to 11. This gives 03h, 0Bh, 13h, 1Bh, 23h, 3Bh, 43h, 4Bh, 53h, 5Bh, 63h and 6Bh, so 2Bh and 33h are never produced.
- R4: Source 4 requests when either `src_flag[4]` (receive) or `ser0_tx_flag` (transmit) is set. Both flags use enable bit 4 and the vector 23h.
- R5: A source is considered only when its `src_en` bit is 1 and `glob_en` is 1. Otherwise its flag has no effect on the outputs.
- R6: A call is taken only on an edge where `cyc_en` and `last_cycle` are 1 and both `ctl_write` and `reti_done` are 0.
- R7: `src_lvl[i]` = 1 puts source i at high level (in-service bit 1); 0 puts it at low level (bit 0). A pending high-level request beats any low-level one. A level is blocked while the in-service bit of that level or of a higher level is set.
- R8: A taken call sets the in-service bit of its level. A strobed final cycle with `reti_done` = 1 clears the highest in-service bit that is set; nothing else clears it.
- R9: Requests are not remembered. A flag that was active in earlier polls but is inactive on the qualifying edge produces no call.
- R10: With a call, `hw_clear` pulses the bit of the winning source only for indices 0, 1, 2, 3, 6, 7, 9 and 10. Sources 4, 5, 8 and 11 never get a hardware clear.
- R11: Outputs are registered. `vec_req` is high for exactly the one cycle after the qualifying edge, and `vec_addr` and `hw_clear` are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle strobe: polling happens on edges where it is 1 |
| last_cycle | input | 1 | Current machine cycle is the last of the executing instruction |
| ctl_write | input | 1 | Executing instruction writes an enable or priority register |
| reti_done | input | 1 | Executing instruction is a return-from-interrupt |
| glob_en | input | 1 | Global interrupt enable |
| src_flag | input | 12 | Request flags, index 0 highest natural priority; bit 4 is serial receive |
| ser0_tx_flag | input | 1 | Serial port 0 transmit flag, shares source 4 |
| src_en | input | 12 | Per-source enable |
| src_lvl | input | 12 | Per-source priority level, 1 = high |
| vec_req | output | 1 | One-cycle hardware call request |
| vec_addr | output | 16 | Vector address for the call |
| hw_clear | output | 12 | One-cycle clear pulse to the served source's flag |
| in_service | output | 2 | In-service bits, bit 1 high level, bit 0 low level |

## Verification
The bench targets collisions in the resolver. With all flags raised, a mistaken scan direction would serve the lowest-ranked source. A high-level source at the bottom of the order must beat every low-level one, and an off-by-one in the vector formula would land on the unused 2Bh or 33h slots. Tests cover the serial transmit flag arriving alone, and the software-only sources, which must never receive a clear pulse. A nested sequence covers two cases: a call at a level already in service, which would re-enter the routine, and a return that clears the wrong level, which would unblock low-level sources too early. Every blocking condition is applied on its own, and a design that latched requests would wrongly serve a flag that had already gone.

// File: rtl/irq_pkg.sv
// Shared constants and helpers for the interrupt arbiter.
// Assumes twelve sources in fixed natural order and two priority levels.
package irq_pkg;
    localparam int NUM_SRC = 12;
    localparam int NUM_LVL = 2;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int VEC_W   = 16;
    // Sources whose flag hardware may clear on a taken call.
    localparam logic [NUM_SRC-1:0] HW_CLR_MASK = 12'b0110_1100_1111;
    // Index of the source that merges two flags (serial port 0).
    localparam int SER0_IDX = 4;

    // Vector address of a source: eight-byte slots from 03h, two slots skipped after index 4.
    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        int slot;
        slot = (int'(idx) <= SER0_IDX) ? int'(idx) : int'(idx) + 2;
        return VEC_W'(3 + 8 * slot);
    endfunction
endpackage

// File: rtl/irq_pick.sv
// Fixed-order priority picker: reports the lowest-index set bit of req.
// Purely combinational; assumes index 0 is the most urgent request.
module irq_pick #(
    parameter int N     = 12,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Scan from the lowest rank upward so the highest-priority bit is written last.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // Winner is a real request and nothing of better rank is pending.
    always_comb begin
        if (valid) begin
            p_win_is_req_r2: assert (req[idx]);
            p_win_lowest_r2: assert ((req & ((N'(1) << idx) - N'(1))) == '0);
        end else begin
            p_idle_no_req_r2: assert (req == '0);
        end
    end
endmodule

// File: rtl/irq_level_track.sv
// In-service level tracker. A taken call sets the bit of its level; a return
// from interrupt clears the highest bit that is set. Assumes calls and returns
// never coincide (the caller blocks calls during a return).
module irq_level_track #(
    parameter int NUM_LVL = 2,
    parameter int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [LVL_W-1:0]   set_lvl,
    input  logic               ret_en,
    output logic [NUM_LVL-1:0] active
);
    logic [NUM_LVL-1:0] top_bit;

    // Isolate the highest set in-service bit.
    always_comb begin
        top_bit = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (active[l]) top_bit = NUM_LVL'(1) << l;
        end
    end

    // Update the in-service bits on calls and returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
        end else if (ret_en) begin
            active <= active & ~top_bit;
        end else if (set_en) begin
            active <= active | (NUM_LVL'(1) << set_lvl);
        end
    end

    p_ret_clears_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && active[NUM_LVL-1]) |=> !active[NUM_LVL-1]);
    p_ret_keeps_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && active[NUM_LVL-1]) |=> active[0] == $past(active[0]));
    p_set_marks_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !ret_en) |=> active[$past(set_lvl)]);
endmodule

// File: rtl/irq_arbiter.sv
// Twelve-source vectored interrupt arbiter. Each strobed machine cycle it
// gates the flags, resolves a winner per level, and, when the core reports a
// safe call point, issues a one-cycle call request carrying the vector.
// Assumes the core holds status lines valid around the strobed edge.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int ADDR_W = VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_en,
    input  logic               last_cycle,
    input  logic               ctl_write,
    input  logic               reti_done,
    input  logic               glob_en,
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic               ser0_tx_flag,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic               vec_req,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [NUM_SRC-1:0] hw_clear,
    output logic [NUM_LVL-1:0] in_service
);
    localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;

    logic [NUM_SRC-1:0] raw_req;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_LVL-1:0] lvl_valid;
    logic [IDX_W-1:0]   lvl_idx [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_allow;
    logic               sel_v;
    logic [IDX_W-1:0]   sel_idx;
    logic [LVL_W-1:0]   sel_lvl;
    logic               safe_pt;
    logic               take;
    logic               ret_ev;

    // Merge the two serial flags into one request and apply all enables.
    always_comb begin
        raw_req           = src_flag;
        raw_req[SER0_IDX] = src_flag[SER0_IDX] | ser0_tx_flag;
        pend              = raw_req & src_en & {NUM_SRC{glob_en}};
    end

    // One picker per priority level over the requests assigned to it.
    for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
        logic [NUM_SRC-1:0] lvl_req;
        // Keep only requests whose level bit matches this picker.
        always_comb lvl_req = pend & ((lv == 0) ? ~src_lvl : src_lvl);
        irq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
            .req   (lvl_req),
            .valid (lvl_valid[lv]),
            .idx   (lvl_idx[lv])
        );
    end

    // A level may interrupt only if no routine at it or above is running.
    always_comb begin
        for (int l = 0; l < NUM_LVL; l++) begin
            lvl_allow[l] = ((in_service >> l) == '0);
        end
    end

    // Choose the highest allowed level that has a winner.
    always_comb begin
        sel_v   = 1'b0;
        sel_idx = '0;
        sel_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_valid[l] && lvl_allow[l]) begin
                sel_v   = 1'b1;
                sel_idx = lvl_idx[l];
                sel_lvl = LVL_W'(l);
            end
        end
    end

    // Call point and return event as seen by the core's status lines.
    always_comb begin
        safe_pt = cyc_en && last_cycle && !ctl_write && !reti_done;
        take    = safe_pt && sel_v;
        ret_ev  = cyc_en && last_cycle && reti_done;
    end

    irq_level_track #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (take),
        .set_lvl (sel_lvl),
        .ret_en  (ret_ev),
        .active  (in_service)
    );

    // Register the call pulse, its vector and the hardware clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_req  <= 1'b0;
            vec_addr <= '0;
            hw_clear <= '0;
        end else begin
            vec_req  <= take;
            hw_clear <= take ? (HW_CLR_MASK & (NUM_SRC'(1) << sel_idx)) : '0;
            if (take) vec_addr <= ADDR_W'(vec_of(sel_idx));
        end
    end

    p_call_point_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(cyc_en && last_cycle && !ctl_write && !reti_done));
    p_global_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(glob_en));
    p_clear_with_call_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clear != '0) |-> vec_req);
    p_clear_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hw_clear));
    p_call_marks_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (in_service != '0));
    p_vec_in_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> (vec_addr[2:0] == 3'd3 && vec_addr != 16'h002B && vec_addr != 16'h0033));
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cyc_en, last_cycle, ctl_write, reti_done, glob_en, ser0_tx_flag;
    logic [11:0] src_flag, src_en, src_lvl;
    logic        vec_req;
    logic [15:0] vec_addr;
    logic [11:0] hw_clear;
    logic [1:0]  in_service;
    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .last_cycle(last_cycle),
        .ctl_write(ctl_write), .reti_done(reti_done), .glob_en(glob_en),
        .src_flag(src_flag), .ser0_tx_flag(ser0_tx_flag), .src_en(src_en),
        .src_lvl(src_lvl), .vec_req(vec_req), .vec_addr(vec_addr),
        .hw_clear(hw_clear), .in_service(in_service)
    );

    // Vector fields: flags, tx, enables, levels, expect call, address, clear.
    localparam int NV = 16;
    localparam logic [65:0] TBL [NV] = '{
        {12'h001, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h0003, 12'h001}, // R2 R3
        {12'hFFF, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h0003, 12'h001}, // R2 all pending
        {12'hFFE, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h000B, 12'h002}, // R2
        {12'h004, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h0013, 12'h004}, // R3
        {12'h008, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h001B, 12'h008}, // R3
        {12'h010, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h0023, 12'h000}, // R4 R10 receive
        {12'h000, 1'b1, 12'hFFF, 12'h000, 1'b1, 16'h0023, 12'h000}, // R4 transmit
        {12'h020, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h003B, 12'h000}, // R3 skip R10
        {12'h040, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h0043, 12'h040}, // R3 R10
        {12'h080, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h004B, 12'h080}, // R3 R10
        {12'h100, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h0053, 12'h000}, // R10 software only
        {12'h600, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h005B, 12'h200}, // R2 R10
        {12'h800, 1'b0, 12'hFFF, 12'h000, 1'b1, 16'h006B, 12'h000}, // R10 software only
        {12'hFFF, 1'b0, 12'h800, 12'h000, 1'b1, 16'h006B, 12'h000}, // R5 enable mask
        {12'hFFF, 1'b0, 12'hFFF, 12'h400, 1'b1, 16'h0063, 12'h400}, // R7 high level wins
        {12'h000, 1'b0, 12'hFFF, 12'h000, 1'b0, 16'h0000, 12'h000}  // idle
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cyc_en = 1'b1; last_cycle = 1'b0; ctl_write = 1'b0; reti_done = 1'b0;
        glob_en = 1'b1; src_flag = '0; ser0_tx_flag = 1'b0; src_en = 12'hFFF; src_lvl = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // One poll at a call point, then check the registered outputs.
    task automatic poll(input string tag, input logic exp_v, input logic [15:0] exp_a);
        tick();
        check(tag, {31'd0, vec_req}, {31'd0, exp_v});
        if (exp_v) check(tag, {16'd0, vec_addr}, {16'd0, exp_a});
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state while inputs request a call
        idle_inputs();
        src_flag = 12'hFFF; last_cycle = 1'b1;
        rst_n = 1'b0;
        tick(); tick();
        check("R1 vec_req", {31'd0, vec_req}, 32'd0);
        check("R1 hw_clear", {20'd0, hw_clear}, 32'd0);
        check("R1 in_service", {30'd0, in_service}, 32'd0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            do_reset();
            src_flag = TBL[k][65:54]; ser0_tx_flag = TBL[k][53];
            src_en = TBL[k][52:41]; src_lvl = TBL[k][40:29]; last_cycle = 1'b1;
            tick();
            idle_inputs();
            check($sformatf("R2/R3 vector %0d req", k), {31'd0, vec_req}, {31'd0, TBL[k][28]});
            if (TBL[k][28]) begin
                check($sformatf("R3 vector %0d addr", k), {16'd0, vec_addr}, {16'd0, TBL[k][27:12]});
                check($sformatf("R10 vector %0d clear", k), {20'd0, hw_clear}, {20'd0, TBL[k][11:0]});
            end
            // R11 pulse lasts one cycle
            tick();
            check($sformatf("R11 vector %0d pulse end", k), {31'd0, vec_req}, 32'd0);
            check($sformatf("R10 vector %0d clear end", k), {20'd0, hw_clear}, 32'd0);
        end

        // R5 global enable off
        do_reset();
        src_flag = 12'hFFF; last_cycle = 1'b1; glob_en = 1'b0;
        poll("R5 global off", 1'b0, 16'h0);
        check("R5 no isr", {30'd0, in_service}, 32'd0);

        // R6 each blocking condition
        do_reset();
        src_flag = 12'h001; last_cycle = 1'b0;
        poll("R6 not last cycle", 1'b0, 16'h0);
        src_flag = 12'h001; last_cycle = 1'b1; ctl_write = 1'b1;
        poll("R6 control write", 1'b0, 16'h0);
        src_flag = 12'h001; last_cycle = 1'b1; reti_done = 1'b1;
        poll("R6 return", 1'b0, 16'h0);
        src_flag = 12'h001; last_cycle = 1'b1; cyc_en = 1'b0;
        poll("R6 no strobe", 1'b0, 16'h0);
        check("R6 no isr", {30'd0, in_service}, 32'd0);

        // R9 request not remembered
        do_reset();
        src_flag = 12'h002; last_cycle = 1'b0;
        tick(); tick();
        src_flag = 12'h000; last_cycle = 1'b1;
        poll("R9 dropped flag", 1'b0, 16'h0);

        // R7 R8 nesting
        do_reset();
        src_flag = 12'h800; last_cycle = 1'b1;
        poll("R7 low call", 1'b1, 16'h006B);
        check("R8 low isr", {30'd0, in_service}, 32'd1);
        src_flag = 12'h001; last_cycle = 1'b1;
        poll("R7 equal level blocked", 1'b0, 16'h0);
        src_flag = 12'h021; src_lvl = 12'h020; last_cycle = 1'b1;
        poll("R7 high preempts", 1'b1, 16'h003B);
        check("R8 both isr", {30'd0, in_service}, 32'd3);
        src_flag = 12'h020; src_lvl = 12'h020; last_cycle = 1'b1;
        poll("R7 high blocked when high active", 1'b0, 16'h0);
        last_cycle = 1'b1; reti_done = 1'b1;
        poll("R8 return no call", 1'b0, 16'h0);
        check("R8 high cleared", {30'd0, in_service}, 32'd1);
        last_cycle = 1'b1; reti_done = 1'b1;
        poll("R8 second return", 1'b0, 16'h0);
        check("R8 low cleared", {30'd0, in_service}, 32'd0);
        src_flag = 12'h001; last_cycle = 1'b1;
        poll("R8 low unblocked", 1'b1, 16'h0003);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule